// File: doc/BRIEF.md
# Privileged control register unit

This block holds the control registers of a small 32-bit RISC core and serves the two decoded operations that move data between them and the general registers: a control read (control register to general register) and a control write (general register to control register). Each operation names its control register with a 5-bit index, so the block sees a space of 32 entries. Eleven of these entries hold state in local flops. Three entries belong to the memory management unit and are passed through to it. The remaining entries are reserved.

Both operations are privileged. When the live status register shows user mode, a read or write does not complete. The block then raises a supervisor-only exception with a fixed cause code and leaves every register untouched. The block also performs the status restore for an exception return, in which the saved status is copied into the live status in one cycle. After any legal write to the status register, it emits a one-cycle pulse so that the core re-evaluates pending interrupts against the new value.

Operations are presented combinationally on the op inputs. Read results, MMU write strobes and the exception outputs are valid in the same cycle. Register updates and the re-check pulse appear after the next rising clock edge.

Top module: `ctl_reg_unit`

## Requirements
- R1: After reset, status reads as 0 (supervisor mode, interrupts disabled), every other local register reads as 0, and irq_recheck is low.
- R2: Indices 0 (status), 1 (saved status), 2 (break status), 3, 4, 5, 7, 12, 13, 14 and 15 are local storage. A legal write of wr_data to one of them is returned by a later read of that index. A read presents its data on rd_data, with rd_valid high, in the same cycle.
- R3: While status bit 1 (user mode) is set, a control read or write asserts exc_valid with exc_cause equal to 10 in that cycle. It produces no rd_valid and no MMU write strobe, and no register changes.
- R4: A legal read whose destination general-register index op_dst is 0 keeps rd_valid low and rd_data at 0.
- R5: Indices 8, 9 and 10 belong to the MMU. A legal write to one of them raises mmu_wr_en with mmu_wr_data equal to wr_data and changes no local register. A legal read of one of them returns mmu_rd_data. mmu_idx always carries op_idx.
- R6: A legal write to index 0 raises irq_recheck for exactly the one cycle that follows the write's clock edge. No other operation raises it.
- R7: An exception-return operation (op_eret) loads status with the saved status (index 1) at the next clock edge. This holds whether or not the core is in user mode, and it never raises exc_valid.
- R8: Indices 6, 11 and 16 to 31 are reserved. Reads of them return 0, and writes to them change nothing.
- R9: When several op inputs are high together, op_eret wins over op_wr, and op_wr wins over op_rd. A losing operation has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_rd | input | 1 | Control read requested this cycle |
| op_wr | input | 1 | Control write requested this cycle |
| op_eret | input | 1 | Exception return requested this cycle |
| op_idx | input | 5 | Control register index |
| op_dst | input | 5 | Destination general register of a read |
| wr_data | input | 32 | Value for a control write |
| mmu_rd_data | input | 32 | Value of the MMU register selected by mmu_idx |
| rd_valid | output | 1 | General register write-back strobe |
| rd_data | output | 32 | Value read, 0 when rd_valid is low |
| mmu_wr_en | output | 1 | Write strobe to the MMU |
| mmu_idx | output | 5 | Index presented to the MMU |
| mmu_wr_data | output | 32 | Data presented to the MMU |
| irq_recheck | output | 1 | Pulse after a status write |
| exc_valid | output | 1 | Supervisor-only exception raised |
| exc_cause | output | 5 | Exception cause, 10 when exc_valid |
| status_o | output | 32 | Live status register |

## Verification
The bench builds the block with its default parameters: a 32-bit data path, a 5-bit index, the user-mode flag in status bit 1 and cause code 10. Under these values the full 32-entry index space can be reached, including the whole upper half of reserved entries, the three MMU pass-through indices and the gaps at 6 and 11. Random status writes drive the core into user mode and back out through exception return. This exercises the fault path against every index and every combination of overlapping operations.

// File: rtl/ctl_reg_unit.sv
module ctl_reg_unit #(
  parameter int DW          = 32,
  parameter int IDX_W       = 5,
  parameter int GPR_W       = 5,
  parameter int CAUSE_W     = 5,
  parameter int USER_BIT    = 1,
  parameter int SUPER_CAUSE = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               op_rd,
  input  logic               op_wr,
  input  logic               op_eret,
  input  logic [IDX_W-1:0]   op_idx,
  input  logic [GPR_W-1:0]   op_dst,
  input  logic [DW-1:0]      wr_data,
  input  logic [DW-1:0]      mmu_rd_data,
  output logic               rd_valid,
  output logic [DW-1:0]      rd_data,
  output logic               mmu_wr_en,
  output logic [IDX_W-1:0]   mmu_idx,
  output logic [DW-1:0]      mmu_wr_data,
  output logic               irq_recheck,
  output logic               exc_valid,
  output logic [CAUSE_W-1:0] exc_cause,
  output logic [DW-1:0]      status_o
);
  localparam int NREG   = 1 << IDX_W;
  localparam int IX_ST  = 0;
  localparam int IX_EST = 1;

  function automatic logic is_mmu(input int i);
    return (i >= 8) && (i <= 10);
  endfunction

  function automatic logic is_store(input int i);
    return (i < 16) && (i != 6) && (i != 11) && !is_mmu(i);
  endfunction

  logic [DW-1:0] bank [NREG];
  logic user, do_wr, do_rd, wr_ok, rd_ok, sel_mmu;
  logic [DW-1:0] sel_data;

  assign user    = bank[IX_ST][USER_BIT];
  assign do_wr   = op_wr & ~op_eret;
  assign do_rd   = op_rd & ~op_eret & ~op_wr;
  assign wr_ok   = do_wr & ~user;
  assign rd_ok   = do_rd & ~user;
  assign sel_mmu = is_mmu(int'(op_idx));

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n) begin
        bank[i] <= '0;
      end else if (is_store(i)) begin
        if (i == IX_ST && op_eret)
          bank[i] <= bank[IX_EST];
        else if (wr_ok && int'(op_idx) == i)
          bank[i] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_recheck <= 1'b0;
    else        irq_recheck <= wr_ok && (int'(op_idx) == IX_ST);
  end

  assign sel_data    = sel_mmu ? mmu_rd_data : bank[op_idx];
  assign rd_valid    = rd_ok && (op_dst != '0);
  assign rd_data     = rd_valid ? sel_data : '0;
  assign mmu_idx     = op_idx;
  assign mmu_wr_en   = wr_ok && sel_mmu;
  assign mmu_wr_data = wr_data;
  assign exc_valid   = (do_wr | do_rd) & user;
  assign exc_cause   = exc_valid ? CAUSE_W'(SUPER_CAUSE) : '0;
  assign status_o    = bank[IX_ST];
endmodule

module ctl_reg_unit_chk #(
  parameter int DW          = 32,
  parameter int IDX_W       = 5,
  parameter int GPR_W       = 5,
  parameter int CAUSE_W     = 5,
  parameter int USER_BIT    = 1,
  parameter int SUPER_CAUSE = 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_rd,
  input logic               op_wr,
  input logic               op_eret,
  input logic [IDX_W-1:0]   op_idx,
  input logic [GPR_W-1:0]   op_dst,
  input logic               rd_valid,
  input logic               mmu_wr_en,
  input logic               irq_recheck,
  input logic               exc_valid,
  input logic [CAUSE_W-1:0] exc_cause,
  input logic [DW-1:0]      status_o
);
  logic usr;
  assign usr = status_o[USER_BIT];

  p_user_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_rd || op_wr) && !op_eret && usr) |-> (exc_valid && !rd_valid && !mmu_wr_en));

  p_fault_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (exc_cause == CAUSE_W'(SUPER_CAUSE)));

  p_fault_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> $stable(status_o));

  p_zero_dst_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_rd && op_dst == '0) |-> !rd_valid);

  p_mmu_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mmu_wr_en |-> (op_wr && !op_eret && !usr && op_idx >= 8 && op_idx <= 10));

  p_recheck_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_wr && !op_eret && !usr && op_idx == '0) |=> irq_recheck);

  p_eret_nofault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_eret |-> !exc_valid);
endmodule

bind ctl_reg_unit ctl_reg_unit_chk #(
  .DW(DW), .IDX_W(IDX_W), .GPR_W(GPR_W), .CAUSE_W(CAUSE_W),
  .USER_BIT(USER_BIT), .SUPER_CAUSE(SUPER_CAUSE)
) u_chk (.*);

// File: tb/ctl_reg_unit_tb.sv
module ctl_reg_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_rd, op_wr, op_eret;
  logic [4:0]  op_idx, op_dst;
  logic [31:0] wr_data, mmu_rd_data;
  logic        rd_valid, mmu_wr_en, irq_recheck, exc_valid;
  logic [31:0] rd_data, mmu_wr_data, status_o;
  logic [4:0]  mmu_idx, exc_cause;

  int checks = 0;
  int errors = 0;
  logic [31:0] m [32];
  logic        exp_rc;

  ctl_reg_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_rd(op_rd), .op_wr(op_wr), .op_eret(op_eret),
    .op_idx(op_idx), .op_dst(op_dst), .wr_data(wr_data), .mmu_rd_data(mmu_rd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .mmu_wr_en(mmu_wr_en), .mmu_idx(mmu_idx),
    .mmu_wr_data(mmu_wr_data), .irq_recheck(irq_recheck), .exc_valid(exc_valid),
    .exc_cause(exc_cause), .status_o(status_o)
  );

  always #10 clk = ~clk;

  function automatic logic f_mmu(input int i);
    return i >= 8 && i <= 10;
  endfunction
  function automatic logic f_res(input int i);
    return i == 6 || i == 11 || i >= 16;
  endfunction
  function automatic logic [31:0] f_read(input int i, input logic [31:0] mrd);
    if (f_mmu(i)) return mrd;
    if (f_res(i)) return 32'h0;
    return m[i];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; op_rd = 0; op_wr = 0; op_eret = 0;
    op_idx = 0; op_dst = 0; wr_data = 0; mmu_rd_data = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 32; i++) m[i] = 32'h0;
    exp_rc = 1'b0;
  endtask

  task automatic step(input logic rd, input logic wr, input logic er, input int idx,
                      input int dst, input logic [31:0] d, input logic [31:0] mrd);
    logic user, e_wr, e_rd, e_fault, e_rv;
    logic [31:0] e_rdata;
    @(negedge clk);
    chk("R2/R7 status", status_o, m[0]);
    chk("R6 irq_recheck", {31'h0, irq_recheck}, {31'h0, exp_rc});
    op_rd = rd; op_wr = wr; op_eret = er; op_idx = 5'(idx); op_dst = 5'(dst);
    wr_data = d; mmu_rd_data = mrd;
    #2;
    user    = m[0][1];
    e_wr    = wr && !er;
    e_rd    = rd && !er && !wr;
    e_fault = (e_wr || e_rd) && user;
    e_rv    = e_rd && !user && dst != 0;
    e_rdata = e_rv ? f_read(idx, mrd) : 32'h0;
    chk("R3 exc_valid", {31'h0, exc_valid}, {31'h0, e_fault});
    chk("R3 exc_cause", {27'h0, exc_cause}, e_fault ? 32'd10 : 32'd0);
    chk("R4/R9 rd_valid", {31'h0, rd_valid}, {31'h0, e_rv});
    chk("R2/R8 rd_data", rd_data, e_rdata);
    chk("R5 mmu_wr_en", {31'h0, mmu_wr_en}, {31'h0, e_wr && !user && f_mmu(idx)});
    chk("R5 mmu_idx", {27'h0, mmu_idx}, 32'(idx));
    if (mmu_wr_en) chk("R5 mmu_wr_data", mmu_wr_data, d);
    @(posedge clk);
    exp_rc = e_wr && !user && idx == 0;
    if (er) m[0] = m[1];
    else if (e_wr && !user && !f_mmu(idx) && !f_res(idx)) m[idx] = d;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    // R1: reset state read back
    for (int i = 0; i < 16; i++) step(1, 0, 0, i, 3, 32'h0, 32'h0);
    // R2 round trip
    step(0, 1, 0, 3, 0, 32'hA5A5_0F0F, 0);
    step(1, 0, 0, 3, 7, 0, 0);
    step(0, 1, 0, 15, 0, 32'h1234_5678, 0);
    step(1, 0, 0, 15, 1, 0, 0);
    // R8 reserved
    step(0, 1, 0, 6, 0, 32'hFFFF_FFFF, 0);
    step(1, 0, 0, 6, 2, 0, 0);
    step(0, 1, 0, 20, 0, 32'hFFFF_FFFF, 0);
    step(1, 0, 0, 20, 2, 0, 0);
    // R5 mmu pass-through
    step(0, 1, 0, 9, 0, 32'hCAFE_0001, 32'h0);
    step(1, 0, 0, 9, 4, 0, 32'h0BAD_F00D);
    // R4 destination zero
    step(1, 0, 0, 3, 0, 0, 0);
    // R6 status write pulse
    step(0, 1, 0, 0, 0, 32'h1, 0);
    step(0, 0, 0, 0, 0, 0, 0);
    // R3 user mode, then R7 return
    step(0, 1, 0, 1, 0, 32'h1, 0);
    step(0, 1, 0, 0, 0, 32'h3, 0);
    step(1, 0, 0, 3, 5, 0, 0);
    step(0, 1, 0, 0, 0, 32'h0, 0);
    step(0, 1, 0, 9, 0, 32'h5, 0);
    step(0, 0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 5, 0, 0);
    // R9 priority
    step(0, 1, 0, 1, 0, 32'h4, 0);
    step(1, 1, 1, 0, 6, 32'h7, 0);
    step(1, 1, 0, 3, 6, 32'h99, 0);
    step(1, 0, 0, 3, 6, 0, 0);
    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 10);
      if (m[0][1] && m[1][1]) do_reset();
      step(r < 4 || r == 8, (r >= 4 && r < 8) || r == 8, r == 9 || ($urandom % 16 == 0),
           int'($urandom % 32), int'($urandom % 4), $urandom, $urandom);
    end
    step(0, 0, 0, 0, 0, 0, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule